// File: doc/BRIEF.md
# Whole-Vector Element Order Reverser

This block reverses the order of the elements across a whole vector register in one step. The element size is chosen at run time from a 2-bit code, so one datapath serves four element widths. The same interface also handles a predicate register. A predicate has one bit for each data byte, and in that mode each element is a group of predicate bits.

The operation is unpredicated, and every element of the result is written. A caller presents the operand, the mode, the size code and a one-cycle start strobe. One clock later the registered result appears on the output together with a valid pulse. The result then holds until the next start. Applying the same reversal twice with the same size gives back the original operand.

Top module: `vrev_top`

## Requirements
- R1: A synchronous reset drives `valid` low and `result` to all zeros on the following clock edge.
- R2: `valid` is high in exactly the cycle after a cycle in which `start` was high, and low after every cycle without `start`.
- R3: In cycles that follow a cycle without `start`, `result` keeps its previous value.
- R4: In data mode (`pred_mode`=0), `size_code` 2'b00, 2'b01, 2'b10 and 2'b11 select elements of 8, 16, 32 and 64 bits. Element i of the result (bits [i*E +: E]) equals source element N-1-i, where N = VEC_W/E.
- R5: In data mode with `size_code`=2'b00, the top byte of the result equals byte 0 of the source, and result byte i equals source byte N-1-i.
- R6: In predicate mode (`pred_mode`=1), the operand is `src[VEC_W/8-1:0]`. An element is a group of 1, 2, 4 or 8 bits for codes 2'b00 to 2'b11. Whole groups are reversed, and the bit order inside each group is kept.
- R7: In predicate mode, `result` bits above VEC_W/8 are zero, and the source bits above VEC_W/8 have no effect.
- R8: Feeding a result back with the same mode and size code reproduces the original operand. In predicate mode this applies to its low VEC_W/8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle strobe that captures a new operation |
| pred_mode | input | 1 | 0: data vector, 1: predicate vector |
| size_code | input | 2 | Element size code (8/16/32/64-bit elements) |
| src | input | VEC_W | Source operand; only the low VEC_W/8 bits are used in predicate mode |
| result | output | VEC_W | Registered reversed operand |
| valid | output | 1 | High for the one cycle after each start |

## Verification
A wrong size selection or a mis-wired lane shows up on `result` in the cycle right after the offending start. The damage is a byte or bit group at a wrong position, which a mirrored reference comparison catches on that clock. A fault in the capture register shows up in a different way: either as a `valid` that fails to track `start`, or as `result` drifting during idle cycles. Both are visible within one cycle. Leakage of source bits into the upper half of a predicate result appears only when the unused bits are non-zero, so the stimulus drives them all high.

// File: rtl/vrev_pkg.sv
package vrev_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_DBL  = 2'b11
  } vrev_size_e;

  localparam int unsigned NUM_SIZES = 4;

  // element width for a size code; base is 8 for data, 1 for predicate
  function automatic int unsigned elem_width(input int unsigned code,
                                             input int unsigned base);
    return base << code;
  endfunction

  // number of elements of that width in a vector of total_w bits
  function automatic int unsigned elem_count(input int unsigned total_w,
                                             input int unsigned code,
                                             input int unsigned base);
    return total_w / elem_width(code, base);
  endfunction

endpackage

// File: rtl/vrev_lane_flip.sv
module vrev_lane_flip #(
  parameter int unsigned TOTAL_W = 256,
  parameter int unsigned ELEM_W  = 8
) (
  input  logic [TOTAL_W-1:0] din,
  output logic [TOTAL_W-1:0] dout
);
  localparam int unsigned N_ELEM = TOTAL_W / ELEM_W;

  for (genvar i = 0; i < N_ELEM; i++) begin : g_lane
    assign dout[i*ELEM_W +: ELEM_W] = din[(N_ELEM-1-i)*ELEM_W +: ELEM_W];
  end
endmodule

// File: rtl/vrev_size_bank.sv
module vrev_size_bank
  import vrev_pkg::*;
#(
  parameter int unsigned TOTAL_W = 256,
  parameter int unsigned BASE_W  = 8
) (
  input  logic [TOTAL_W-1:0] din,
  input  logic [1:0]         size_code,
  output logic [TOTAL_W-1:0] dout
);
  logic [NUM_SIZES-1:0][TOTAL_W-1:0] flipped;

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    vrev_lane_flip #(
      .TOTAL_W(TOTAL_W),
      .ELEM_W (elem_width(s, BASE_W))
    ) u_flip (
      .din (din),
      .dout(flipped[s])
    );
  end

  always_comb begin
    dout = flipped[size_code];
  end
endmodule

// File: rtl/vrev_out_stage.sv
module vrev_out_stage #(
  parameter int unsigned W = 256
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         vld
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= '0;
      vld <= 1'b0;
    end else begin
      vld <= load;
      if (load) q <= d;
    end
  end
endmodule

// File: rtl/vrev_top.sv
module vrev_top #(
  parameter int unsigned VEC_W = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             pred_mode,
  input  logic [1:0]       size_code,
  input  logic [VEC_W-1:0] src,
  output logic [VEC_W-1:0] result,
  output logic             valid
);
  localparam int unsigned PRED_W = VEC_W / 8;

  logic [VEC_W-1:0]  data_flip;
  logic [PRED_W-1:0] pred_flip;
  logic [VEC_W-1:0]  next_result;
  logic              capture;

  vrev_size_bank #(.TOTAL_W(VEC_W), .BASE_W(8)) u_data_bank (
    .din      (src),
    .size_code(size_code),
    .dout     (data_flip)
  );

  vrev_size_bank #(.TOTAL_W(PRED_W), .BASE_W(1)) u_pred_bank (
    .din      (src[PRED_W-1:0]),
    .size_code(size_code),
    .dout     (pred_flip)
  );

  assign capture     = start;
  assign next_result = pred_mode ? {{(VEC_W-PRED_W){1'b0}}, pred_flip} : data_flip;

  vrev_out_stage #(.W(VEC_W)) u_out (
    .clk (clk),
    .rst (rst),
    .load(capture),
    .d   (next_result),
    .q   (result),
    .vld (valid)
  );
endmodule

// File: rtl/vrev_chk.sv
module vrev_chk #(
  parameter int unsigned VEC_W = 256
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             pred_mode,
  input logic [1:0]       size_code,
  input logic [VEC_W-1:0] src,
  input logic [VEC_W-1:0] result,
  input logic             valid
);
  localparam int unsigned PRED_W = VEC_W / 8;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!valid && result == '0));

  // R2
  valid_after_start_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> valid);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !start |=> !valid);

  // R3
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(result));

  // R5
  byte_mirror_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !pred_mode && size_code == 2'b00) |=>
      (result[VEC_W-1 -: 8] == $past(src[7:0])));

  // R4
  dbl_mirror_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !pred_mode && size_code == 2'b11) |=>
      (result[63:0] == $past(src[VEC_W-1 -: 64])));

  // R7
  pred_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (start && pred_mode) |=> (result[VEC_W-1:PRED_W] == '0));
endmodule

bind vrev_top vrev_chk #(.VEC_W(VEC_W)) u_vrev_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .pred_mode(pred_mode),
  .size_code(size_code),
  .src      (src),
  .result   (result),
  .valid    (valid)
);

// File: tb/vrev_top_test.sv
module vrev_top_test;
  localparam int VEC_W  = 256;
  localparam int PRED_W = VEC_W / 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic             pred_mode = 1'b0;
  logic [1:0]       size_code = 2'b00;
  logic [VEC_W-1:0] src = '0;
  logic [VEC_W-1:0] result;
  logic             valid;

  int    n_vec  = 0;
  int    n_fail = 0;
  string req_tag = "R1";

  logic [VEC_W-1:0] exp_result;
  logic             exp_valid;

  vrev_top #(.VEC_W(VEC_W)) uut (
    .clk(clk), .rst(rst), .start(start), .pred_mode(pred_mode),
    .size_code(size_code), .src(src), .result(result), .valid(valid)
  );

  always #5 clk = ~clk;

  // behavioural reference: walk every output bit and find its source bit
  function automatic logic [VEC_W-1:0] model_flip(input logic pm, input int code,
                                                  input logic [VEC_W-1:0] v);
    int tot = pm ? PRED_W : VEC_W;
    int ew  = (pm ? 1 : 8) << code;
    int n   = tot / ew;
    logic [VEC_W-1:0] r = '0;
    for (int b = 0; b < tot; b++) r[b] = v[(n - 1 - b / ew) * ew + b % ew];
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      exp_valid  <= 1'b0;
      exp_result <= '0;
    end else begin
      exp_valid <= start;
      if (start) exp_result <= model_flip(pred_mode, int'(size_code), src);
    end
  end

  task automatic check(input string req, input logic [VEC_W-1:0] act,
                       input logic [VEC_W-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (!rst) begin
      check({req_tag, " valid R2"}, {{(VEC_W-1){1'b0}}, valid},
            {{(VEC_W-1){1'b0}}, exp_valid});
      check({req_tag, " result"}, result, exp_result);
    end
  end

  function automatic logic [VEC_W-1:0] rand_vec();
    logic [VEC_W-1:0] v;
    for (int w = 0; w < VEC_W / 32; w++) v[w*32 +: 32] = $urandom;
    return v;
  endfunction

  // drive one operation; returns the result seen one cycle later
  task automatic run_op(input logic pm, input logic [1:0] code,
                        input logic [VEC_W-1:0] v, output logic [VEC_W-1:0] r);
    @(negedge clk);
    req_tag   = pm ? "R6" : "R4";
    start     = 1'b1;
    pred_mode = pm;
    size_code = code;
    src       = v;
    @(negedge clk);
    start = 1'b0;
    src   = rand_vec();
    r     = result;
  endtask

  task automatic idle(input int n);
    req_tag = "R3";
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin : main
    logic [VEC_W-1:0] r1, r2, pat, ones;
    ones = '1;
    for (int i = 0; i < VEC_W / 8; i++) pat[i*8 +: 8] = 8'(i);

    repeat (3) @(negedge clk);
    src = rand_vec();
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 valid", {{(VEC_W-1){1'b0}}, valid}, '0);
    check("R1 result", result, '0);

    // R5: byte ramp, full byte mirror
    run_op(1'b0, 2'b00, pat, r1);
    check("R5 top byte", {{(VEC_W-8){1'b0}}, r1[VEC_W-1 -: 8]}, '0);
    for (int i = 0; i < VEC_W / 8; i++) begin
      check("R5 byte", {{(VEC_W-8){1'b0}}, r1[i*8 +: 8]},
            {{(VEC_W-8){1'b0}}, 8'(VEC_W/8 - 1 - i)});
    end

    // R4: ramp at each larger element size
    run_op(1'b0, 2'b01, pat, r1);
    check("R4 half low", {{(VEC_W-16){1'b0}}, r1[15:0]},
          {{(VEC_W-16){1'b0}}, 8'(VEC_W/8-1), 8'(VEC_W/8-2)});
    run_op(1'b0, 2'b10, pat, r1);
    check("R4 word low", {{(VEC_W-32){1'b0}}, r1[31:0]},
          {{(VEC_W-32){1'b0}}, pat[VEC_W-1 -: 32]});
    run_op(1'b0, 2'b11, pat, r1);
    check("R4 dbl low", {{(VEC_W-64){1'b0}}, r1[63:0]},
          {{(VEC_W-64){1'b0}}, pat[VEC_W-1 -: 64]});
    idle(3);

    // R6: single set predicate bit at each group size
    run_op(1'b1, 2'b00, 256'h1, r1);
    check("R6 size0", r1, 256'h8000_0000);
    run_op(1'b1, 2'b01, 256'h1, r1);
    check("R6 size1", r1, 256'h4000_0000);
    run_op(1'b1, 2'b10, 256'h1, r1);
    check("R6 size2", r1, 256'h1000_0000);
    run_op(1'b1, 2'b11, 256'h1, r1);
    check("R6 size3", r1, 256'h0100_0000);

    // R7: upper source bits set must not leak
    run_op(1'b1, 2'b10, ones, r1);
    check("R7 upper zero", r1, {{(VEC_W-PRED_W){1'b0}}, {PRED_W{1'b1}}});
    run_op(1'b1, 2'b01, {{(VEC_W-PRED_W){1'b1}}, 32'h0000_0003}, r1);
    check("R7 ignore upper", r1, 256'hC000_0000);
    idle(2);

    // R8: double application restores the operand, both modes, all sizes
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 4; c++) begin
        pat = rand_vec();
        run_op(1'(m), 2'(c), pat, r1);
        run_op(1'(m), 2'(c), r1, r2);
        req_tag = "R8";
        check("R8 involution", r2,
              m == 1 ? {{(VEC_W-PRED_W){1'b0}}, pat[PRED_W-1:0]} : pat);
      end
    end

    // back-to-back random traffic with gaps (R2, R3, R4, R6 via model)
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      start     = ($urandom % 3) != 0;
      pred_mode = 1'($urandom);
      size_code = 2'($urandom);
      src       = rand_vec();
      req_tag   = start ? (pred_mode ? "R6" : "R4") : "R2";
    end
    @(negedge clk);
    start = 1'b0;
    idle(4);

    // R1: reset again after traffic
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 re-reset result", result, '0);
    check("R1 re-reset valid", {{(VEC_W-1){1'b0}}, valid}, '0);
    idle(2);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule